// File: doc/BRIEF.md
# Speech-Block Convolutional Encoder with Diagonal Interleave Addressing

This block turns one 267-bit speech-channel data block into 456 protected bits. It tags each output bit with the place it takes in the transmit frames. The first 189 input bits go through a rate-1/2 convolutional code with four bits of memory, which gives 378 coded bits. Input bits 182 to 259 are then appended unchanged as coded bits 378 to 455, and input bits 260 to 266 are dropped. Every output bit carries a frame number and a bit position inside a 114-bit frame. A downstream frame buffer can therefore write the bit straight to its interleaved place. Each block is spread over eight consecutive frames, and the next block starts four frames later.

Input bits arrive serially. A start flag marks bit 0, and the block index is sampled together with that bit. Once all 267 bits are in, the block emits its 456 output tuples on 456 consecutive cycles, one per cycle. While it emits, it accepts no input. The interleave position uses a running modular accumulator instead of a multiplier.

Top module: `speech_ilv_encoder`

## Requirements
- R1: While reset is held and after reset is released, `out_valid_o` stays 0 until a complete block has been loaded.
- R2: A block begins with a valid bit that has `in_start_i` high (input bit 0) and continues with the next 266 valid bits. Valid bits without start while idle are ignored. Idle cycles between valid bits are allowed.
- R3: In the cycle after input bit 266 is accepted, `out_valid_o` rises. It stays high for exactly 456 consecutive cycles, and those cycles carry coded indices j = 0 to 455 in order.
- R4: For even j = 2k < 378, the output bit is d[k] ^ d[k-3] ^ d[k-4]. Any d with a negative index is 0.
- R5: For odd j = 2k+1 < 378, the output bit is d[k] ^ d[k-1] ^ d[k-3] ^ d[k-4]. Any d with a negative index is 0.
- R6: For 378 ≤ j ≤ 455, the output bit is d[182 + j - 378]. Input bits 260 to 266 have no effect on any output.
- R7: `out_frame_o` = 4·B + (j mod 8), where B is the value of `blk_idx_i` sampled with input bit 0. Later changes to `blk_idx_i` have no effect until the next block.
- R8: `out_pos_o` = 2·((49·j) mod 57) + ((j mod 8) div 4). It always lies in 0 to 113.
- R9: Within one block, frame offsets 0 to 3 each receive 57 distinct even positions, and offsets 4 to 7 each receive 57 distinct odd positions.
- R10: Over the coded outputs, for 1 ≤ j ≤ 184, the bits at 2j, 2j+1, 2j+2, 2j+3, 2j+6, 2j+8 and 2j+9 XOR to zero.
- R11: While `out_valid_o` is high, `in_valid_i`, `in_start_i`, `in_bit_i` and `blk_idx_i` have no effect on the current or the next block.
- R12: A start-flagged valid bit during loading discards the partial block and makes that bit input bit 0 of a new block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input bit valid |
| in_start_i | input | 1 | Marks input bit 0 of a block |
| in_bit_i | input | 1 | Serial data bit |
| blk_idx_i | input | BLK_W | Block index, sampled with bit 0 |
| out_valid_o | output | 1 | Output tuple valid |
| out_bit_o | output | 1 | Coded bit |
| out_frame_o | output | BLK_W+3 | Destination frame, 4·block + offset |
| out_pos_o | output | 7 | Destination bit position in the frame |

## Verification
The hardest condition to reach from the ports is a block in which the history registers and the uncoded tail are exercised on their own. A single set bit at input 0 shows the response of the code and proves that the delay line starts at zero. A single set bit at input 185 must show up both in the coded part and in the copied tail. A single set bit at input 260 must leave every output at zero. Some blocks are driven with idle gaps between bits, with stray start flags and data during emission, and with an aborted partial block. In each case the next block still has to match the model bit for bit. The accumulator-based positions are checked against the closed-form formula for every output, and for every block the coverage of even and odd lanes and the parity identity are checked over the whole block.

// File: rtl/sie_pkg.sv
package sie_pkg;
  localparam int unsigned IN_BITS    = 267;
  localparam int unsigned CODED_IN   = 189;
  localparam int unsigned OUT_BITS   = 456;
  localparam int unsigned CODED_OUT  = 2 * CODED_IN;
  localparam int unsigned TAIL_FIRST = 182;
  localparam int unsigned TAIL_BITS  = OUT_BITS - CODED_OUT;
  localparam int unsigned HIST_BITS  = 4;
  localparam int unsigned ILV_STEP   = 49;
  localparam int unsigned ILV_MOD    = 57;
  localparam int unsigned ILV_LANES  = 8;
  localparam int unsigned LANE_W     = $clog2(ILV_LANES);
  localparam int unsigned ACC_W      = $clog2(ILV_MOD);
  localparam int unsigned POS_W      = ACC_W + 1;
  localparam int unsigned CNT_W      = $clog2(OUT_BITS);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_EMIT = 2'd2
  } sie_state_e;
endpackage

// File: rtl/sie_store.sv
module sie_store
  import sie_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_en_i,
  input  logic             load_bit_i,
  input  logic [CNT_W-1:0] load_idx_i,
  input  logic             emit_en_i,
  input  logic [CNT_W-1:0] emit_idx_i,
  output logic             coded_bit_o
);
  logic [CODED_IN-1:0]  coded_q;
  logic [TAIL_BITS-1:0] tail_q;
  logic [HIST_BITS-1:0] hist_q;  // hist_q[n] = d[k-1-n]

  logic in_coded, in_tail, emit_tail, emit_odd, cur;

  assign in_coded  = load_idx_i < CNT_W'(CODED_IN);
  assign in_tail   = (load_idx_i >= CNT_W'(TAIL_FIRST)) &&
                     (load_idx_i <  CNT_W'(TAIL_FIRST + TAIL_BITS));
  assign emit_tail = emit_idx_i >= CNT_W'(CODED_OUT);
  assign emit_odd  = emit_idx_i[0];
  assign cur       = coded_q[0];

  always_comb begin
    if (emit_tail)     coded_bit_o = tail_q[0];
    else if (emit_odd) coded_bit_o = cur ^ hist_q[0] ^ hist_q[2] ^ hist_q[3];
    else               coded_bit_o = cur ^ hist_q[2] ^ hist_q[3];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coded_q <= '0;
      tail_q  <= '0;
      hist_q  <= '0;
    end else if (load_en_i) begin
      // shift in from the top so bit 0 lands at index 0 after a full load
      if (in_coded) coded_q <= {load_bit_i, coded_q[CODED_IN-1:1]};
      if (in_tail)  tail_q  <= {load_bit_i, tail_q[TAIL_BITS-1:1]};
      if (load_idx_i == '0) hist_q <= '0;
    end else if (emit_en_i) begin
      if (emit_tail) begin
        tail_q <= {1'b0, tail_q[TAIL_BITS-1:1]};
      end else if (emit_odd) begin
        coded_q <= {1'b0, coded_q[CODED_IN-1:1]};
        hist_q  <= {hist_q[HIST_BITS-2:0], cur};
      end
    end
  end

  // R11
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_en_i && emit_en_i));
endmodule

// File: rtl/sie_addr.sv
module sie_addr
  import sie_pkg::*;
#(
  parameter int unsigned BLK_W = 6,
  localparam int unsigned FR_W = BLK_W + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic [FR_W-1:0]  frame_o,
  output logic [POS_W-1:0] pos_o
);
  logic [LANE_W-1:0] lane_q;
  logic [ACC_W-1:0]  acc_q, acc_next;
  logic [ACC_W:0]    acc_sum;

  // modular accumulator: acc tracks (ILV_STEP * j) mod ILV_MOD
  assign acc_sum  = {1'b0, acc_q} + (ACC_W+1)'(ILV_STEP);
  assign acc_next = (acc_sum >= (ACC_W+1)'(ILV_MOD)) ?
                    ACC_W'(acc_sum - (ACC_W+1)'(ILV_MOD)) : ACC_W'(acc_sum);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q <= '0;
      acc_q  <= '0;
    end else if (clr_i) begin
      lane_q <= '0;
      acc_q  <= '0;
    end else if (step_i) begin
      lane_q <= lane_q + 1'b1;
      acc_q  <= acc_next;
    end
  end

  assign frame_o = {1'b0, blk_i, 2'b00} + FR_W'(lane_q);
  assign pos_o   = {acc_q, lane_q[LANE_W-1]};

  // R8
  acc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q < ACC_W'(ILV_MOD));
  // R8
  acc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !clr_i |=> acc_q != $past(acc_q));
endmodule

// File: rtl/speech_ilv_encoder.sv
module speech_ilv_encoder
  import sie_pkg::*;
#(
  parameter int unsigned BLK_W = 6,
  localparam int unsigned FR_W = BLK_W + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             in_start_i,
  input  logic             in_bit_i,
  input  logic [BLK_W-1:0] blk_idx_i,
  output logic             out_valid_o,
  output logic             out_bit_o,
  output logic [FR_W-1:0]  out_frame_o,
  output logic [POS_W-1:0] out_pos_o
);
  sie_state_e       state_q;
  logic [CNT_W-1:0] cnt_q, load_idx;
  logic [BLK_W-1:0] blk_q;
  logic             busy, take_start, load_en, load_last, emit_en, emit_last;

  assign busy       = state_q == ST_EMIT;
  assign take_start = in_valid_i && in_start_i && !busy;
  assign load_en    = in_valid_i && !busy && (in_start_i || state_q == ST_LOAD);
  assign load_idx   = take_start ? '0 : cnt_q;
  assign load_last  = load_en && (load_idx == CNT_W'(IN_BITS - 1));
  assign emit_en    = busy;
  assign emit_last  = busy && (cnt_q == CNT_W'(OUT_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      blk_q   <= '0;
    end else if (busy) begin
      if (emit_last) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (load_en) begin
      if (take_start) blk_q <= blk_idx_i;
      if (load_last) begin
        state_q <= ST_EMIT;
        cnt_q   <= '0;
      end else begin
        state_q <= ST_LOAD;
        cnt_q   <= load_idx + 1'b1;
      end
    end
  end

  sie_store u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_en_i   (load_en),
    .load_bit_i  (in_bit_i),
    .load_idx_i  (load_idx),
    .emit_en_i   (emit_en),
    .emit_idx_i  (cnt_q),
    .coded_bit_o (out_bit_o)
  );

  sie_addr #(.BLK_W(BLK_W)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (load_last),
    .step_i  (emit_en),
    .blk_i   (blk_q),
    .frame_o (out_frame_o),
    .pos_o   (out_pos_o)
  );

  assign out_valid_o = busy;

  // R3
  emit_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_valid_o) |-> $past(cnt_q) == CNT_W'(OUT_BITS - 1));
  // R3
  emit_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(load_en) && $past(load_idx) == CNT_W'(IN_BITS - 1));
  // R11
  blk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && $past(out_valid_o) |-> blk_q == $past(blk_q));
  // R8
  pos_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_pos_o < POS_W'(2 * ILV_MOD));
endmodule

// File: tb/speech_ilv_encoder_bench.sv
module speech_ilv_encoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BLK_W = 6;
  localparam int FR_W  = BLK_W + 3;

  typedef struct packed {
    logic [3:0]  mode;   // 0 zeros, 1 ones, 2 single one at seed, 3 lfsr
    logic [15:0] seed;
    logic [5:0]  blk;
    logic        gaps;
    logic        noise;
    logic [3:0]  pad;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VEC [NVEC] = '{
    '{4'd0, 16'd0,      6'd0,  1'b0, 1'b0, 4'd0},
    '{4'd1, 16'd0,      6'd3,  1'b1, 1'b0, 4'd0},
    '{4'd2, 16'd0,      6'd1,  1'b0, 1'b0, 4'd0},
    '{4'd2, 16'd260,    6'd2,  1'b0, 1'b1, 4'd0},
    '{4'd2, 16'd185,    6'd7,  1'b1, 1'b0, 4'd0},
    '{4'd3, 16'hACE1,   6'd63, 1'b0, 1'b1, 4'd0},
    '{4'd3, 16'h1234,   6'd10, 1'b1, 1'b1, 4'd0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0, in_start = 1'b0, in_bit = 1'b0;
  logic [BLK_W-1:0] blk_idx = '0;
  logic out_valid, out_bit;
  logic [FR_W-1:0] out_frame;
  logic [6:0] out_pos;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  speech_ilv_encoder #(.BLK_W(BLK_W)) u_speech_ilv_encoder (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_start_i(in_start),
    .in_bit_i(in_bit), .blk_idx_i(blk_idx), .out_valid_o(out_valid),
    .out_bit_o(out_bit), .out_frame_o(out_frame), .out_pos_o(out_pos)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit db(input logic [266:0] d, input int x);
    return (x < 0) ? 1'b0 : d[x];
  endfunction

  function automatic bit exp_bit(input logic [266:0] d, input int j);
    int k = j / 2;
    if (j >= 378) return d[182 + j - 378];
    if (j % 2 == 0) return db(d, k) ^ db(d, k-3) ^ db(d, k-4);
    return db(d, k) ^ db(d, k-1) ^ db(d, k-3) ^ db(d, k-4);
  endfunction

  function automatic logic [266:0] make_data(input vec_t v);
    logic [266:0] d = '0;
    logic [15:0] s = v.seed;
    for (int k = 0; k < 267; k++) begin
      case (v.mode)
        4'd1: d[k] = 1'b1;
        4'd2: d[k] = (k == int'(v.seed));
        4'd3: begin
          s = s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
          d[k] = s[0];
        end
        default: d[k] = 1'b0;
      endcase
    end
    return d;
  endfunction

  task automatic run_block(input logic [266:0] d, input int blk, input bit gaps, input bit noise);
    bit ob [456];
    bit seen [8][114];
    for (int f = 0; f < 8; f++)
      for (int p = 0; p < 114; p++) seen[f][p] = 1'b0;
    for (int k = 0; k < 267; k++) begin
      if (gaps && k > 0) begin
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0; in_bit = ~d[k];
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_start = (k == 0);
      in_bit   = d[k];
      blk_idx  = (k == 0) ? BLK_W'(blk) : ~BLK_W'(blk);  // R7: later values ignored
    end
    for (int j = 0; j < 456; j++) begin
      @(negedge clk);
      chk("R3 valid", int'(out_valid), 1);
      if (j < 378) chk((j % 2 == 0) ? "R4 even bit" : "R5 odd bit", int'(out_bit), int'(exp_bit(d, j)));
      else         chk("R6 tail bit", int'(out_bit), int'(exp_bit(d, j)));
      chk("R7 frame", int'(out_frame), 4 * blk + (j % 8));
      chk("R8 pos", int'(out_pos), 2 * ((49 * j) % 57) + ((j % 8) / 4));
      ob[j] = out_bit;
      if (out_pos < 114) seen[j % 8][out_pos] = 1'b1;
      if (noise) begin  // R11: stimulus during emission
        in_valid = 1'b1;
        in_start = $urandom() % 2 == 0;
        in_bit   = $urandom() % 2 == 0;
        blk_idx  = BLK_W'($urandom());
      end else begin
        in_valid = 1'b0;
        in_start = 1'b0;
      end
    end
    @(negedge clk);
    chk("R3 valid after 456", int'(out_valid), 0);
    in_valid = 1'b0; in_start = 1'b0;
    for (int j = 1; j <= 184; j++)
      chk("R10 parity", int'(ob[2*j] ^ ob[2*j+1] ^ ob[2*j+2] ^ ob[2*j+3] ^ ob[2*j+6] ^ ob[2*j+8] ^ ob[2*j+9]), 0);
    for (int f = 0; f < 8; f++) begin
      int good = 0;
      int any = 0;
      for (int p = 0; p < 114; p++) begin
        if (seen[f][p]) begin
          any++;
          if (p % 2 == f / 4) good++;
        end
      end
      chk("R9 lane fill", good, 57);
      chk("R9 lane count", any, 57);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [266:0] d;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(out_valid), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", int'(out_valid), 0);

    // R2: valid bits without start while idle are ignored
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_start = 1'b0; in_bit = 1'b1;
      if (k % 50 == 0) chk("R2 stray bits", int'(out_valid), 0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 stray bits end", int'(out_valid), 0);

    for (int v = 0; v < NVEC; v++) begin
      d = make_data(VEC[v]);
      run_block(d, int'(VEC[v].blk), VEC[v].gaps, VEC[v].noise);
    end

    // R12: partial block aborted by a new start
    for (int k = 0; k < 120; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_start = (k == 0); in_bit = 1'b1; blk_idx = 6'd40;
    end
    chk("R12 no output from partial", int'(out_valid), 0);
    d = make_data('{4'd3, 16'h5A5A, 6'd5, 1'b0, 1'b0, 4'd0});
    run_block(d, 5, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule